// File: doc/BRIEF.md
# Queue Lock Unit

The queue lock unit grants one shared resource to several requesters in strict arrival order. It keeps a ticket counter and a ring of per-slot tokens, one slot per requester. An accepted acquire takes the current ticket and advances the counter in the same step. The ticket modulo the slot count picks a private slot, and the requester waits until that slot holds the token. When the requester enters, it clears its own slot. When it releases, it raises the token in the slot after its own, so the next ticket holder takes over without any shared polling.

Each requester has a level `acq_i` bit and a one-cycle `rel_i` pulse. Its `grant_o` bit is high while it holds the lock. Acquires raised in the same cycle are accepted one per cycle, the lowest index first. The unit records each requester's slot, so a release carries no argument. A release from a requester that does not hold the lock is flagged on `rel_err_o`.

Top module: `queue_lock_unit`

## Requirements
- R1: After reset no grant and no error are asserted, and slot 0 holds the token, so the first accepted acquire is granted without waiting for any release.
- R2: Among idle requesters raising `acq_i` in the same cycle, exactly one is accepted per clock edge, the lowest index first. Each accepted requester gets the next ticket.
- R3: An acquire driven before edge k while the lock is free is accepted at edge k, and `grant_o` rises after edge k+1.
- R4: At most one bit of `grant_o` is high in any cycle.
- R5: Grants are issued in the order in which acquires were accepted.
- R6: A `rel_i` pulse from the holder sampled at edge k drops its grant after edge k. If another requester is already waiting, the next ticket holder's grant rises after edge k+1.
- R7: A `rel_i` pulse from a requester that is not holding raises `rel_err_o` for exactly the following cycle. It changes no grant and no queue order.
- R8: `acq_i` from a requester that is waiting or holding is ignored. A holder that has dropped `acq_i` before releasing is not queued again.
- R9: Handoff stays correct after the ticket counter has wrapped both the slot ring and its own width.
- R10: A requester that releases and raises `acq_i` again joins the back of the queue, behind every requester already waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acq_i | input | N_REQ | Per-requester acquire level |
| rel_i | input | N_REQ | Per-requester release pulse |
| grant_o | output | N_REQ | Per-requester lock held |
| rel_err_o | output | 1 | Release from a non-holder seen in the previous cycle |

## Verification
The bench runs every non-empty subset of four requesters, with all members raising `acq_i` together. This shows whether the priority order among simultaneous acquires becomes the grant order and whether each handoff takes exactly one idle cycle. One run has the first holder re-acquire at release, which separates true FIFO order from plain index priority. Stray releases from waiting and idle requesters show whether an error is flagged without any effect on the queue. The total number of grants wraps a narrowed ticket counter several times.

// File: rtl/qlock_pkg.sv
package qlock_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } cl_state_e;
endpackage

// File: rtl/qlock_ticket.sv
module qlock_ticket #(
  parameter int N_REQ  = 4,
  parameter int TAIL_W = 8,
  localparam int SLOT_W = $clog2(N_REQ)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_REQ-1:0]  req_i,
  output logic [N_REQ-1:0]  acc_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [TAIL_W-1:0] tail_q;
  logic              found;

  // fixed priority, lowest index wins
  always_comb begin
    acc_o = '0;
    found = 1'b0;
    for (int i = 0; i < N_REQ; i++) begin
      if (req_i[i] && !found) begin
        acc_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tail_q <= '0;
    else if (found) tail_q <= tail_q + 1'b1;
  end

  assign slot_o = tail_q[SLOT_W-1:0];

  p_one_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(acc_o));
  p_tail_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |=> $stable(tail_q));
  p_accept_if_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |-> (acc_o != '0));
endmodule

// File: rtl/qlock_slots.sv
module qlock_slots #(
  parameter int N_REQ = 4,
  localparam int SLOT_W = $clog2(N_REQ)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_REQ-1:0]              clr_i,
  input  logic [N_REQ-1:0][SLOT_W-1:0]  clr_slot_i,
  input  logic [N_REQ-1:0]              set_i,
  input  logic [N_REQ-1:0][SLOT_W-1:0]  set_slot_i,
  output logic [N_REQ-1:0]              flags_o
);
  logic [N_REQ-1:0] flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    for (int r = 0; r < N_REQ; r++)
      if (clr_i[r]) flags_d[clr_slot_i[r]] = 1'b0;
    for (int r = 0; r < N_REQ; r++)
      if (set_i[r]) flags_d[set_slot_i[r]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= N_REQ'(1);
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  p_token_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flags_q));
  p_single_setter_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(set_i));
endmodule

// File: rtl/qlock_client.sv
module qlock_client #(
  parameter int N_REQ = 4,
  localparam int SLOT_W = $clog2(N_REQ)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [N_REQ-1:0]  flags_i,
  input  logic              rel_i,
  output logic              idle_o,
  output logic              hold_o,
  output logic              clr_o,
  output logic [SLOT_W-1:0] clr_slot_o,
  output logic              set_o,
  output logic [SLOT_W-1:0] set_slot_o,
  output logic              rel_bad_o
);
  import qlock_pkg::*;

  cl_state_e         state_q, state_d;
  logic [SLOT_W-1:0] slot_q;
  logic              enter;

  assign enter = (state_q == ST_WAIT) && flags_i[slot_q];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (acc_i) state_d = ST_WAIT;
      ST_WAIT: if (enter) state_d = ST_HOLD;
      ST_HOLD: if (rel_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && acc_i) slot_q <= slot_i;
    end
  end

  assign idle_o     = (state_q == ST_IDLE);
  assign hold_o     = (state_q == ST_HOLD);
  assign clr_o      = enter;
  assign clr_slot_o = slot_q;
  assign set_o      = hold_o && rel_i;
  assign set_slot_o = slot_q + 1'b1;
  assign rel_bad_o  = rel_i && !hold_o;

  p_hold_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && !rel_i) |=> hold_o);
  p_enter_on_token_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $past(flags_i[slot_q]));
  p_slot_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_o |=> (idle_o || $stable(slot_q)));
endmodule

// File: rtl/queue_lock_unit.sv
module queue_lock_unit #(
  parameter int N_REQ  = 4,
  parameter int TAIL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] acq_i,
  input  logic [N_REQ-1:0] rel_i,
  output logic [N_REQ-1:0] grant_o,
  output logic             rel_err_o
);
  localparam int SLOT_W = $clog2(N_REQ);

  logic [N_REQ-1:0]             idle, req, acc, clr, set, bad, flags;
  logic [N_REQ-1:0][SLOT_W-1:0] clr_slot, set_slot;
  logic [SLOT_W-1:0]            tail_slot;
  logic                         rel_err_q;

  assign req = acq_i & idle;

  qlock_ticket #(.N_REQ(N_REQ), .TAIL_W(TAIL_W)) i_ticket (
    .clk_i, .rst_ni, .req_i(req), .acc_o(acc), .slot_o(tail_slot)
  );

  qlock_slots #(.N_REQ(N_REQ)) i_slots (
    .clk_i, .rst_ni,
    .clr_i(clr), .clr_slot_i(clr_slot),
    .set_i(set), .set_slot_i(set_slot),
    .flags_o(flags)
  );

  for (genvar r = 0; r < N_REQ; r++) begin : g_client
    qlock_client #(.N_REQ(N_REQ)) i_client (
      .clk_i, .rst_ni,
      .acc_i(acc[r]), .slot_i(tail_slot), .flags_i(flags), .rel_i(rel_i[r]),
      .idle_o(idle[r]), .hold_o(grant_o[r]),
      .clr_o(clr[r]), .clr_slot_o(clr_slot[r]),
      .set_o(set[r]), .set_slot_o(set_slot[r]),
      .rel_bad_o(bad[r])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rel_err_q <= 1'b0;
    else         rel_err_q <= |bad;
  end

  assign rel_err_o = rel_err_q;

  p_mutex_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  p_rel_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rel_i & ~grant_o) != '0) |=> rel_err_o);
  p_rel_clean_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rel_i & ~grant_o) == '0) |=> !rel_err_o);
  p_drop_on_rel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rel_i & grant_o) != '0) |=> ((grant_o & $past(rel_i & grant_o)) == '0));
endmodule

// File: tb/test_queue_lock_unit.sv
module test_queue_lock_unit;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic [N-1:0] acq, rel;
  logic [N-1:0] grant;
  logic         err;
  int           n_run = 0;
  int           n_fail = 0;

  always #5 clk = ~clk;

  queue_lock_unit #(.N_REQ(N), .TAIL_W(4)) i_queue_lock_unit (
    .clk_i(clk), .rst_ni(rst_ni), .acq_i(acq), .rel_i(rel),
    .grant_o(grant), .rel_err_o(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // all members of mask raise acq together; optional requeue and stray release
  task automatic run_round(input int mask, input bit requeue);
    int order[$];
    int first;
    for (int i = 0; i < N; i++) if (mask[i]) order.push_back(i);
    first = order[0];
    acq = N'(mask);
    step();
    chk(grant == '0, "R3", "grant one edge after acquire", grant, 0);
    step();
    chk(grant == N'(1 << first), "R3", "grant two edges after acquire",
        grant, 1 << first);
    for (int k = 0; k < order.size(); k++) begin
      int h = order[k];
      acq[h] = 1'b0;
      step();
      acq[h] = 1'b1;  // ignored while holding (R8)
      step();
      acq[h] = 1'b0;
      if (requeue && k == 0) begin
        rel[N-1] = 1'b1;  // waiter releases: stray (R7)
        step();
        rel = '0;
        chk(err == 1'b1, "R7", "error after stray release", err, 1);
        chk(grant == N'(1 << h), "R7", "holder kept after stray release",
            grant, 1 << h);
        step();
        chk(err == 1'b0, "R7", "error lasts one cycle", err, 0);
      end else begin
        step();
      end
      chk(grant == N'(1 << h), "R4", "holder stable and exclusive",
          grant, 1 << h);
      rel[h] = 1'b1;
      if (requeue && k == 0) begin
        acq[h] = 1'b1;
        order.push_back(h);
      end
      step();
      rel = '0;
      chk(grant == '0, "R6", "grant drops after release", grant, 0);
      if (k + 1 < order.size()) begin
        step();
        chk(grant == N'(1 << order[k+1]), "R5", "next ticket granted",
            grant, 1 << order[k+1]);
      end else begin
        repeat (4) step();
        chk(grant == '0, "R8", "no requeue once acquire dropped", grant, 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    acq = '0;
    rel = '0;
    repeat (3) step();
    chk(grant == '0, "R1", "grant in reset", grant, 0);
    chk(err == 1'b0, "R1", "error in reset", err, 0);
    rst_ni = 1'b1;
    step();
    chk(grant == '0, "R1", "grant after reset", grant, 0);
    // idle stray release
    rel[2] = 1'b1;
    step();
    rel = '0;
    chk(err == 1'b1, "R7", "error after idle release", err, 1);
    step();
    chk(err == 1'b0, "R7", "error clears", err, 0);
    chk(grant == '0, "R7", "no grant from stray release", grant, 0);
    // R1 first round from reset; R2 priority over every subset; R9 wrap
    for (int m = 1; m < (1 << N); m++) run_round(m, 1'b0);
    // R10 holder re-acquires at release and must be served last
    run_round((1 << N) - 1, 1'b1);
    for (int m = (1 << N) - 1; m > 0; m--) run_round(m, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule